// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a 32-bit register datapath and a byte-addressed data memory that is one word wide. For each access request it forms the effective byte address from a base register value and a signed 12-bit displacement. For stores it places the register data on the right memory byte lanes and raises a per-lane write strobe. For loads it takes the word that the memory returns one cycle later, selects the addressed byte or the whole word, and extends it for register write-back.

Five operations are supported: word load, signed byte load, unsigned byte load, word store and byte store. Lanes follow little-endian order, so byte lane k (bits 8k+7:8k of the memory word) holds the byte at address bits 1:0 equal to k. A word access whose address is not a multiple of four is not performed. The block raises a misalignment flag instead, so that software can handle the access. Because the memory read has one cycle of latency, the block registers the lane and the extension kind of an accepted load. The caller therefore does not have to hold the request.

Top module: `lsu_lane_fmt`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32, combinationally.
- R2: A word store (`op_i` = 3) with `req_valid_i` high and address bits 1:0 = 00 drives `mem_wstrb_o` = 4'b1111 and `mem_wdata_o` = `store_data_i`.
- R3: A byte store (`op_i` = 4) with `req_valid_i` high sets only strobe bit `mem_addr_o[1:0]`, and it replicates `store_data_i[7:0]` on all four data lanes. It is never flagged misaligned.
- R4: `misalign_o` is high exactly when `req_valid_i` is high, `op_i` is a word load (0) or a word store (3), and `mem_addr_o[1:0]` is nonzero. While it is high, `mem_wstrb_o` is 4'b0000.
- R5: `load_valid_o` is high in the cycle after an accepted load: `req_valid_i` high, `op_i` of 0, 1 or 2, and not misaligned. It is low in every other cycle, and `load_data_o` is zero while it is low.
- R6: For a word load (`op_i` = 0), `load_data_o` equals `mem_rdata_i` in full.
- R7: For a signed byte load (`op_i` = 1), `load_data_o[7:0]` is lane `addr[1:0]` of `mem_rdata_i`, and bits 31:8 copy that byte's bit 7. For example, the word 0xFFFFF8F5 read at byte offset 1 gives 0xFFFFFFF8.
- R8: For an unsigned byte load (`op_i` = 2), `load_data_o[7:0]` is the addressed lane and bits 31:8 are zero. The same example gives 0x000000F8.
- R9: When `req_valid_i` is low, or when `op_i` is 5, 6 or 7, the strobe is zero, `misalign_o` is low and no load completes in the next cycle.
- R10: While `rst_ni` is low, and in the first cycle after it is released, `load_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request present this cycle |
| op_i | input | 3 | Operation: 0 word load, 1 signed byte load, 2 unsigned byte load, 3 word store, 4 byte store |
| base_i | input | 32 | Base register value |
| offset_i | input | 12 | Signed byte displacement |
| store_data_i | input | 32 | Source register value for stores |
| mem_addr_o | output | 32 | Effective byte address |
| mem_wstrb_o | output | 4 | Per-lane write strobe |
| mem_wdata_o | output | 32 | Lane-steered write data |
| misalign_o | output | 1 | Misaligned word access raised |
| mem_rdata_i | input | 32 | Memory read word, one cycle after the request |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
The case that is hardest to reach from the ports is an address whose low two bits come only from a carry or a borrow in the base-plus-displacement sum. In that case neither `base_i` nor `offset_i` alone shows the misalignment or the lane. Random bases combined with random negative and positive displacements reach such sums often, and they exercise the flag, the strobe and the lane choice together. Directed accesses then store a word whose byte at offset 1 has bit 7 set, and read it back with both byte-load kinds through a bench memory that applies the strobes.

// File: rtl/lsu_fmt_pkg.sv
package lsu_fmt_pkg;
  typedef enum logic [2:0] {
    OP_LW  = 3'd0,
    OP_LBS = 3'd1,
    OP_LBU = 3'd2,
    OP_SW  = 3'd3,
    OP_SB  = 3'd4
  } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_fmt_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [XLEN-1:0]  addr_o,
  output logic             misalign_o
);
  localparam int NBYTES = XLEN / 8;
  localparam int LANE_W = $clog2(NBYTES);

  logic [XLEN-1:0] off_ext;
  logic            word_op;

  assign off_ext    = {{(XLEN-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign addr_o     = base_i + off_ext;
  assign word_op    = (op_i == OP_LW) || (op_i == OP_SW);
  assign misalign_o = req_i && word_op && (addr_o[LANE_W-1:0] != '0);
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_fmt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                           req_i,
  input  logic [2:0]                     op_i,
  input  logic                           misalign_i,
  input  logic [$clog2(XLEN/8)-1:0]      lane_i,
  input  logic [XLEN-1:0]                sdata_i,
  output logic [XLEN/8-1:0]              wstrb_o,
  output logic [XLEN-1:0]                wdata_o
);
  localparam int NBYTES = XLEN / 8;
  localparam int LANE_W = $clog2(NBYTES);

  logic is_sw, is_sb, go;
  assign is_sw = (op_i == OP_SW);
  assign is_sb = (op_i == OP_SB);
  assign go    = req_i && !misalign_i;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign wdata_o[8*g +: 8] = is_sw ? sdata_i[8*g +: 8] :
                               is_sb ? sdata_i[7:0] : 8'h00;
    assign wstrb_o[g] = go && (is_sw || (is_sb && (lane_i == LANE_W'(g))));
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_fmt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_i,
  input  logic [2:0]                kind_i,
  input  logic [$clog2(XLEN/8)-1:0] lane_i,
  input  logic [XLEN-1:0]           rdata_i,
  output logic                      valid_o,
  output logic [XLEN-1:0]           data_o
);
  localparam int NBYTES = XLEN / 8;
  localparam int LANE_W = $clog2(NBYTES);

  logic              valid_q;
  logic [2:0]        kind_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        bytes [NBYTES];
  logic [7:0]        sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      kind_q  <= OP_LW;
      lane_q  <= '0;
    end else begin
      valid_q <= take_i;
      if (take_i) begin
        kind_q <= kind_i;
        lane_q <= lane_i;
      end
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign bytes[g] = rdata_i[8*g +: 8];
  end
  assign sel = bytes[lane_q];

  always_comb begin
    data_o = '0;
    if (valid_q) begin
      case (kind_q)
        OP_LBS:  data_o = {{(XLEN-8){sel[7]}}, sel};
        OP_LBU:  data_o = {{(XLEN-8){1'b0}}, sel};
        default: data_o = rdata_i;
      endcase
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/lsu_lane_fmt.sv
module lsu_lane_fmt
  import lsu_fmt_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       op_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]  store_data_i,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN/8-1:0] mem_wstrb_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             misalign_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             load_valid_o,
  output logic [XLEN-1:0]  load_data_o
);
  localparam int NBYTES = XLEN / 8;
  localparam int LANE_W = $clog2(NBYTES);

  logic is_load, take;

  lsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
    .req_i      (req_valid_i),
    .op_i       (op_i),
    .base_i     (base_i),
    .offset_i   (offset_i),
    .addr_o     (mem_addr_o),
    .misalign_o (misalign_o)
  );

  lsu_store_steer #(.XLEN(XLEN)) u_store (
    .req_i      (req_valid_i),
    .op_i       (op_i),
    .misalign_i (misalign_o),
    .lane_i     (mem_addr_o[LANE_W-1:0]),
    .sdata_i    (store_data_i),
    .wstrb_o    (mem_wstrb_o),
    .wdata_o    (mem_wdata_o)
  );

  assign is_load = (op_i == OP_LW) || (op_i == OP_LBS) || (op_i == OP_LBU);
  assign take    = req_valid_i && is_load && !misalign_o;

  lsu_load_extract #(.XLEN(XLEN)) u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .kind_i  (op_i),
    .lane_i  (mem_addr_o[LANE_W-1:0]),
    .rdata_i (mem_rdata_i),
    .valid_o (load_valid_o),
    .data_o  (load_data_o)
  );
endmodule

// File: rtl/lsu_lane_fmt_chk.sv
module lsu_lane_fmt_chk #(
  parameter int XLEN = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        op_i,
  input logic [XLEN/8-1:0] mem_wstrb_o,
  input logic              misalign_o,
  input logic              load_valid_o,
  input logic [XLEN-1:0]   load_data_o
);
  a_r4_no_strobe_on_misalign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_wstrb_o == '0));

  a_r3_byte_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd4) |-> ($countones(mem_wstrb_o) == 1 && !misalign_o));

  a_r2_word_strobe_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd3 && !misalign_o) |-> (mem_wstrb_o == '1));

  a_r5_load_follows_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i <= 3'd2 && !misalign_o) |=> load_valid_o);

  a_r5_no_stray_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && op_i <= 3'd2 && !misalign_o) |=> !load_valid_o);

  a_r5_idle_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_valid_o |-> (load_data_o == '0));

  a_r8_unsigned_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd2) |=> (load_data_o[XLEN-1:8] == '0));

  a_r7_signed_upper_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 3'd1) |=> (load_data_o[XLEN-1:8] == {(XLEN-8){load_data_o[7]}}));

  a_r9_no_strobe_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || op_i > 3'd4) |-> (mem_wstrb_o == '0 && !misalign_o));
endmodule

bind lsu_lane_fmt lsu_lane_fmt_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .op_i         (op_i),
  .mem_wstrb_o  (mem_wstrb_o),
  .misalign_o   (misalign_o),
  .load_valid_o (load_valid_o),
  .load_data_o  (load_data_o)
);

// File: tb/lsu_lane_fmt_tb_top.sv
module lsu_lane_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] base = '0;
  logic [11:0] offset = '0;
  logic [31:0] sdata = '0;
  logic [31:0] addr;
  logic [3:0]  wstrb;
  logic [31:0] wdata;
  logic        misalign;
  logic [31:0] rdata = '0;
  logic        lvalid;
  logic [31:0] ldata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  lsu_lane_fmt dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .op_i         (op),
    .base_i       (base),
    .offset_i     (offset),
    .store_data_i (sdata),
    .mem_addr_o   (addr),
    .mem_wstrb_o  (wstrb),
    .mem_wdata_o  (wdata),
    .misalign_o   (misalign),
    .mem_rdata_i  (rdata),
    .load_valid_o (lvalid),
    .load_data_o  (ldata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_addr(input logic [31:0] b, input logic [11:0] o);
    return b + {{20{o[11]}}, o};
  endfunction

  function automatic logic e_mis(input logic v, input logic [2:0] p, input logic [31:0] a);
    return v && (p == 3'd0 || p == 3'd3) && (a[1:0] != 2'b00);
  endfunction

  function automatic logic [3:0] e_strb(input logic v, input logic [2:0] p, input logic [31:0] a);
    if (!v) return 4'h0;
    if (p == 3'd3) return (a[1:0] == 2'b00) ? 4'hF : 4'h0;
    if (p == 3'd4) return 4'b0001 << a[1:0];
    return 4'h0;
  endfunction

  function automatic logic [31:0] e_load(input logic [2:0] p, input logic [1:0] ln, input logic [31:0] w);
    logic [7:0] b;
    b = w[8*ln +: 8];
    if (p == 3'd1) return {{24{b[7]}}, b};
    if (p == 3'd2) return {24'h0, b};
    return w;
  endfunction

  task automatic access(input logic v, input logic [2:0] p, input logic [31:0] b,
                        input logic [11:0] o, input logic [31:0] d);
    logic [31:0] a;
    logic [3:0]  s;
    logic        took;
    @(negedge clk);
    req_valid = v; op = p; base = b; offset = o; sdata = d;
    a = e_addr(b, o);
    s = e_strb(v, p, a);
    took = v && (p <= 3'd2) && !e_mis(v, p, a);
    #1;
    check("R1 addr", addr, a);
    check("R4 misalign", {31'h0, misalign}, {31'h0, e_mis(v, p, a)});
    if (p == 3'd4) check("R3 strobe", {28'h0, wstrb}, {28'h0, s});
    else if (p == 3'd3) check("R2 strobe", {28'h0, wstrb}, {28'h0, s});
    else check("R9 strobe", {28'h0, wstrb}, 32'h0);
    if (v && p == 3'd3) check("R2 wdata", wdata, d);
    if (v && p == 3'd4) check("R3 wdata", wdata, {4{d[7:0]}});
    for (int k = 0; k < 4; k++)
      if (s[k]) mem[a[5:2]][8*k +: 8] = wdata[8*k +: 8];
    @(negedge clk);
    req_valid = 1'b0;
    rdata = mem[a[5:2]];
    #1;
    check("R5 load_valid", {31'h0, lvalid}, {31'h0, took});
    if (took && p == 3'd0) check("R6 word load", ldata, e_load(p, a[1:0], rdata));
    else if (took && p == 3'd1) check("R7 signed byte", ldata, e_load(p, a[1:0], rdata));
    else if (took && p == 3'd2) check("R8 unsigned byte", ldata, e_load(p, a[1:0], rdata));
    else check("R5 idle data", ldata, 32'h0);
  endtask

  initial begin
    #(10 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    for (int i = 0; i < 16; i++) mem[i] = $urandom;
    #17;
    check("R10 reset load_valid", {31'h0, lvalid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 after release", {31'h0, lvalid}, 32'h0);
    // R7 R8 directed: word store then byte loads at offset 1
    access(1'b1, 3'd3, 32'h0000_0100, 12'h000, 32'hFFFF_F8F5);
    access(1'b1, 3'd1, 32'h0000_0100, 12'h001, 32'h0);
    check("R7 example", ldata, 32'hFFFF_FFF8);
    access(1'b1, 3'd2, 32'h0000_0102, 12'hFFF, 32'h0);
    check("R8 example", ldata, 32'h0000_00F8);
    // R4: misalignment only through a carry
    access(1'b1, 3'd0, 32'h0000_00FF, 12'h002, 32'h0);
    access(1'b1, 3'd3, 32'h0000_0203, 12'h7FF, 32'hDEAD_BEEF);
    access(1'b1, 3'd0, 32'h0000_0107, 12'hFF9, 32'h0);
    // R3: each byte lane
    for (int k = 0; k < 4; k++) access(1'b1, 3'd4, 32'h0000_0040, 12'(k), 32'h1234_5680 + k);
    access(1'b1, 3'd0, 32'h0000_0040, 12'h000, 32'h0);
    check("R3 bytes landed", ldata, 32'h8382_8180);
    // R9: invalid codes and no request
    access(1'b0, 3'd3, 32'h0000_0010, 12'h000, 32'hFFFF_FFFF);
    access(1'b0, 3'd0, 32'h0000_0010, 12'h000, 32'h0);
    for (int c = 5; c < 8; c++) access(1'b1, 3'(c), 32'h0000_0011, 12'h000, 32'h0);
    // random mix
    for (int i = 0; i < 400; i++)
      access(($urandom % 8) != 0, 3'($urandom % 8), $urandom, 12'($urandom), $urandom);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule